// File: doc/BRIEF.md
# Alarm Interrupt and Clock Output Controller

This block drives the single shared output pin of a real-time clock. The pin can carry an active-low alarm interrupt, or it can carry a clock derived from the 32.768 kHz oscillator that also clocks the block. A two-bit frequency select in the control word chooses between these uses. Any nonzero code hands the pin to the clock output and masks the alarm function on it.

Two single-cycle alarm-match strobes come from the time comparator. Each alarm has its own enable bit and its own status flag. In latched mode, a match on an enabled alarm sets that alarm's flag, and the pin stays low until the flag is cleared through the clear input. In pulsed mode, every match on an enabled alarm drives a low pulse of fixed length (1/64 s) on the pin, and no re-arming is needed between matches.

Top module: `rtcIrqClkOut`

## Requirements
- R1: After reset, both status flags are 0. With the control word at zero, the pin is high.
- R2: The control word is `{freqSel[1:0], pulseMode, almEn1, almEn0}` (bit 0 = alarm 0 enable). A match strobe on an enabled alarm sets that alarm's flag at the next clock edge. The flag then holds until its clear bit (clearFlags[0] for alarm 0, clearFlags[1] for alarm 1) is raised. A set and a clear in the same cycle leave the flag set.
- R3: With freqSel = 00 and pulseMode = 0, the pin is low while any enabled alarm has its flag set. It returns high in the cycle after the flag is cleared.
- R4: With both alarms enabled, a match on either alarm alone asserts the pin.
- R5: With freqSel = 00 and pulseMode = 1, each match of an enabled alarm drives the pin low for exactly PULSE_LEN cycles (default 512, i.e. 1/64 s), starting the cycle after the match. Later matches pulse again with no clear in between.
- R6: In pulsed mode with both alarms enabled, separate matches of alarm 0 and alarm 1 each produce their own full pulse.
- R7: With freqSel = 01, the pin follows the oscillator clock: high while the clock is high and low while it is low.
- R8: With freqSel = 10, the pin is a 50% duty clock of period MID_DIV (default 8) cycles. After the select changes, it is low for the first MID_DIV/2 cycles and then high.
- R9: With freqSel = 11, the pin is a 50% duty clock of period SLOW_DIV (default 32768) cycles, low for the first half after the select changes.
- R10: With a nonzero freqSel, alarm matches do not change the pin. They still set the flags of enabled alarms.
- R11: A match on a disabled alarm sets no flag and does not change the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkOsc | input | 1 | 32.768 kHz oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWord | input | 5 | {freqSel[1:0], pulseMode, almEn1, almEn0} |
| matchA0 | input | 1 | Alarm 0 match strobe |
| matchA1 | input | 1 | Alarm 1 match strobe |
| clearFlags | input | 2 | Per-alarm status clear |
| pinOutN | output | 1 | Shared interrupt / clock output pin |
| flagA0 | output | 1 | Alarm 0 status flag |
| flagA1 | output | 1 | Alarm 1 status flag |

## Verification
A divider that is wrongly phased or not restarted shows up as a low/high pattern that is shifted within the first period after a select change. The bench samples every cycle of one period, so for the 4096 Hz code the error appears within 8 cycles. A pulse counter that loads or decrements wrongly changes the count of low cycles, which the bench measures exactly after each match. A flag or enable gating error shows on the flag outputs one cycle after the match. The same error shows on the pin in that cycle when latched mode is selected.

// File: rtl/rtcIrqClkOut_pkg.sv
package rtcIrqClkOut_pkg;
  typedef struct packed {
    logic [1:0] freqSel;
    logic       pulseMode;
    logic       almEn1;
    logic       almEn0;
  } ctrlWord_t;

  typedef struct packed {
    logic divRestart;
    logic pulseActive;
    logic latchedAssert;
  } pinStrobes_t;
endpackage

// File: rtl/rtcIrqCtrl.sv
module rtcIrqCtrl
  import rtcIrqClkOut_pkg::*;
#(
  parameter int PULSE_LEN = 512
) (
  input  logic        clkOsc,
  input  logic        rstN,
  input  ctrlWord_t   ctrl,
  input  logic        matchA0,
  input  logic        matchA1,
  input  logic [1:0]  clearFlags,
  output pinStrobes_t strobes,
  output logic        flagA0,
  output logic        flagA1
);
  localparam int CW = $clog2(PULSE_LEN + 1);

  logic          trig0, trig1, pulseTrig;
  logic [CW-1:0] pulseCnt;
  logic [1:0]    selPrev;

  assign trig0     = matchA0 & ctrl.almEn0;
  assign trig1     = matchA1 & ctrl.almEn1;
  assign pulseTrig = ctrl.pulseMode & (ctrl.freqSel == 2'b00) & (trig0 | trig1);

  always_ff @(posedge clkOsc or negedge rstN) begin
    if (!rstN) begin
      flagA0 <= 1'b0;
      flagA1 <= 1'b0;
    end else begin
      if (trig0) flagA0 <= 1'b1;
      else if (clearFlags[0]) flagA0 <= 1'b0;
      if (trig1) flagA1 <= 1'b1;
      else if (clearFlags[1]) flagA1 <= 1'b0;
    end
  end

  always_ff @(posedge clkOsc or negedge rstN) begin
    if (!rstN) pulseCnt <= '0;
    else if (pulseTrig) pulseCnt <= CW'(PULSE_LEN);
    else if (pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
  end

  always_ff @(posedge clkOsc or negedge rstN) begin
    if (!rstN) selPrev <= 2'b00;
    else selPrev <= ctrl.freqSel;
  end

  assign strobes.divRestart    = (ctrl.freqSel != selPrev);
  assign strobes.pulseActive   = (pulseCnt != '0);
  assign strobes.latchedAssert = ~ctrl.pulseMode &
                                 ((flagA0 & ctrl.almEn0) | (flagA1 & ctrl.almEn1));

  p_flag_set_r2: assert property (@(posedge clkOsc) disable iff (!rstN)
    (matchA0 && ctrl.almEn0) |=> flagA0);
  p_flag_clear_r2: assert property (@(posedge clkOsc) disable iff (!rstN)
    (clearFlags[1] && !matchA1) |=> !flagA1);
  p_disabled_no_flag_r11: assert property (@(posedge clkOsc) disable iff (!rstN)
    (!flagA0 && !ctrl.almEn0) |=> !flagA0);
  p_pulse_start_r5: assert property (@(posedge clkOsc) disable iff (!rstN)
    (ctrl.pulseMode && ctrl.freqSel == 2'b00 && (trig0 || trig1)) |=> strobes.pulseActive);
endmodule

// File: rtl/rtcClkDivider.sv
module rtcClkDivider #(
  parameter int DIV = 8
) (
  input  logic clkOsc,
  input  logic rstN,
  input  logic restart,
  output logic phase
);
  localparam int HALF = DIV / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [DW-1:0] cnt;

  always_ff @(posedge clkOsc or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (restart) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt == DW'(HALF - 1)) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_restart_phase_r8: assert property (@(posedge clkOsc) disable iff (!rstN)
    restart |=> (!phase && cnt == '0));
endmodule

// File: rtl/rtcPinPath.sv
module rtcPinPath
  import rtcIrqClkOut_pkg::*;
#(
  parameter int MID_DIV  = 8,
  parameter int SLOW_DIV = 32768
) (
  input  logic        clkOsc,
  input  logic        rstN,
  input  logic [1:0]  freqSel,
  input  pinStrobes_t strobes,
  output logic        pinOutN
);
  localparam int NDIV = 2;

  logic [NDIV-1:0] phases;

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    rtcClkDivider #(.DIV(g == 0 ? MID_DIV : SLOW_DIV)) u_div (
      .clkOsc (clkOsc),
      .rstN   (rstN),
      .restart(strobes.divRestart),
      .phase  (phases[g])
    );
  end

  always_comb begin
    unique case (freqSel)
      2'b00:   pinOutN = ~(strobes.pulseActive | strobes.latchedAssert);
      2'b01:   pinOutN = clkOsc;
      2'b10:   pinOutN = phases[0];
      default: pinOutN = phases[1];
    endcase
  end

  p_slow_restart_r9: assert property (@(posedge clkOsc) disable iff (!rstN)
    strobes.divRestart |=> !phases[1]);
endmodule

// File: rtl/rtcIrqClkOut.sv
module rtcIrqClkOut
  import rtcIrqClkOut_pkg::*;
#(
  parameter int PULSE_LEN = 512,
  parameter int MID_DIV   = 8,
  parameter int SLOW_DIV  = 32768
) (
  input  logic       clkOsc,
  input  logic       rstN,
  input  logic [4:0] ctrlWord,
  input  logic       matchA0,
  input  logic       matchA1,
  input  logic [1:0] clearFlags,
  output logic       pinOutN,
  output logic       flagA0,
  output logic       flagA1
);
  ctrlWord_t   ctrl;
  pinStrobes_t strobes;

  assign ctrl = ctrlWord_t'(ctrlWord);

  rtcIrqCtrl #(.PULSE_LEN(PULSE_LEN)) u_ctrl (
    .clkOsc    (clkOsc),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .matchA0   (matchA0),
    .matchA1   (matchA1),
    .clearFlags(clearFlags),
    .strobes   (strobes),
    .flagA0    (flagA0),
    .flagA1    (flagA1)
  );

  rtcPinPath #(.MID_DIV(MID_DIV), .SLOW_DIV(SLOW_DIV)) u_path (
    .clkOsc (clkOsc),
    .rstN   (rstN),
    .freqSel(ctrl.freqSel),
    .strobes(strobes),
    .pinOutN(pinOutN)
  );

  p_latched_low_r3: assert property (@(posedge clkOsc) disable iff (!rstN)
    (ctrl.freqSel == 2'b00 && !ctrl.pulseMode && flagA0 && ctrl.almEn0) |-> !pinOutN);
endmodule

// File: tb/rtcIrqClkOut_tb.sv
module rtcIrqClkOut_tb;
  localparam int PULSE_LEN = 512;
  localparam int MID_DIV   = 8;
  localparam int SLOW_DIV  = 32768;

  logic       clkOsc = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] ctrlWord = '0;
  logic       matchA0 = 1'b0, matchA1 = 1'b0;
  logic [1:0] clearFlags = '0;
  logic       pinOutN, flagA0, flagA1;
  int checks = 0, errors = 0;

  always #2.5 clkOsc = ~clkOsc;

  rtcIrqClkOut #(.PULSE_LEN(PULSE_LEN), .MID_DIV(MID_DIV), .SLOW_DIV(SLOW_DIV)) u_dut (
    .clkOsc(clkOsc), .rstN(rstN), .ctrlWord(ctrlWord), .matchA0(matchA0),
    .matchA1(matchA1), .clearFlags(clearFlags), .pinOutN(pinOutN),
    .flagA0(flagA0), .flagA1(flagA1)
  );

  function automatic logic [4:0] mk(logic [1:0] sel, logic pm, logic e1, logic e0);
    return {sel, pm, e1, e0};
  endfunction

  task automatic step();
    @(posedge clkOsc);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearAll();
    clearFlags = 2'b11;
    step();
    clearFlags = 2'b00;
  endtask

  task automatic countLow(output int lows);
    lows = 0;
    while (pinOutN == 1'b0 && lows < PULSE_LEN * 4) begin
      lows++;
      step();
    end
  endtask

  task automatic tReset();
    check("R1 flagA0 after reset", flagA0, 0);
    check("R1 flagA1 after reset", flagA1, 0);
    check("R1 pin after reset", pinOutN, 1);
  endtask

  task automatic tLatched();
    ctrlWord = mk(2'b00, 0, 0, 1);
    clearAll();
    matchA0 = 1; step(); matchA0 = 0;
    check("R2 flag set", flagA0, 1);
    check("R3 pin low latched", pinOutN, 0);
    repeat (5) step();
    check("R3 pin held low", pinOutN, 0);
    matchA0 = 1; clearFlags = 2'b01; step(); matchA0 = 0; clearFlags = 0;
    check("R2 set beats clear", flagA0, 1);
    clearFlags = 2'b01; step(); clearFlags = 0;
    check("R2 flag cleared", flagA0, 0);
    check("R3 pin released", pinOutN, 1);
  endtask

  task automatic tBothOr();
    ctrlWord = mk(2'b00, 0, 1, 1);
    clearAll();
    matchA1 = 1; step(); matchA1 = 0;
    check("R4 alarm1 alone asserts", pinOutN, 0);
    check("R4 flagA1 set", flagA1, 1);
    check("R4 flagA0 untouched", flagA0, 0);
    clearAll();
    check("R4 released", pinOutN, 1);
    matchA0 = 1; step(); matchA0 = 0;
    check("R4 alarm0 alone asserts", pinOutN, 0);
    clearAll();
  endtask

  task automatic tPulsed();
    int lows;
    ctrlWord = mk(2'b00, 1, 0, 1);
    clearAll();
    for (int i = 0; i < 2; i++) begin
      matchA0 = 1; step(); matchA0 = 0;
      countLow(lows);
      check("R5 pulse length", lows, PULSE_LEN);
      check("R5 pin high after pulse", pinOutN, 1);
      repeat (3) step();
    end
    clearAll();
  endtask

  task automatic tPulsedBoth();
    int lows;
    ctrlWord = mk(2'b00, 1, 1, 1);
    clearAll();
    matchA0 = 1; step(); matchA0 = 0;
    countLow(lows);
    check("R6 alarm0 pulse", lows, PULSE_LEN);
    step();
    matchA1 = 1; step(); matchA1 = 0;
    countLow(lows);
    check("R6 alarm1 pulse", lows, PULSE_LEN);
    clearAll();
  endtask

  task automatic tFast();
    ctrlWord = mk(2'b01, 0, 0, 0);
    step();
    for (int i = 0; i < 3; i++) begin
      check("R7 pin high with clock high", pinOutN, 1);
      #2.5;
      check("R7 pin low with clock low", pinOutN, 0);
      step();
    end
  endtask

  task automatic tMid();
    int bad = 0;
    ctrlWord = mk(2'b01, 0, 0, 0);
    step();
    ctrlWord = mk(2'b10, 0, 0, 0);
    step();
    for (int i = 0; i < 2 * MID_DIV; i++) begin
      if (pinOutN != (((i % MID_DIV) >= MID_DIV / 2) ? 1'b1 : 1'b0)) bad++;
      step();
    end
    check("R8 mid divider pattern mismatches", bad, 0);
  endtask

  task automatic tSlow();
    int bad = 0;
    ctrlWord = mk(2'b11, 0, 0, 0);
    step();
    for (int i = 0; i < SLOW_DIV; i++) begin
      if (pinOutN != ((i >= SLOW_DIV / 2) ? 1'b1 : 1'b0)) bad++;
      step();
    end
    check("R9 slow divider pattern mismatches", bad, 0);
  endtask

  task automatic tMasked();
    int bad = 0;
    ctrlWord = mk(2'b00, 0, 0, 1);
    clearAll();
    ctrlWord = mk(2'b10, 0, 0, 1);
    step();
    for (int i = 0; i < 2 * MID_DIV; i++) begin
      if (i == 1) matchA0 = 1;
      if (pinOutN != (((i % MID_DIV) >= MID_DIV / 2) ? 1'b1 : 1'b0)) bad++;
      step();
      matchA0 = 0;
    end
    check("R10 clock unaffected by alarm", bad, 0);
    check("R10 flag still set", flagA0, 1);
    ctrlWord = mk(2'b00, 0, 0, 0);
    clearAll();
  endtask

  task automatic tDisabled();
    ctrlWord = mk(2'b00, 0, 0, 1);
    clearAll();
    matchA1 = 1; step(); matchA1 = 0;
    check("R11 disabled alarm no flag", flagA1, 0);
    check("R11 disabled alarm pin idle", pinOutN, 1);
    ctrlWord = mk(2'b00, 1, 1, 0);
    matchA0 = 1; step(); matchA0 = 0;
    check("R11 disabled alarm0 no pulse", pinOutN, 1);
    check("R11 disabled alarm0 no flag", flagA0, 0);
  endtask

  initial begin
    repeat (3) step();
    tReset();
    rstN = 1'b1;
    step();
    tReset();
    tLatched();
    tBothOr();
    tPulsed();
    tPulsedBoth();
    tFast();
    tMid();
    tSlow();
    tMasked();
    tDisabled();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clkOsc);
    checks++;
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule